// File: doc/BRIEF.md
# Nibble-Serial Lookup-ALU Instruction Sequencer

This block is the control sequencer of a small Harvard-architecture processor. The processor has no arithmetic logic of its own. All ALU work is done by a lookup table held in the same ROM as the program. Each clock is one slot, and four slots make one process cycle: FETCH, READ, EXEC and WRITE. ROM is touched only in FETCH and EXEC. RAM is touched only in READ and WRITE, so another agent can use each memory in the slots the CPU leaves free.

An instruction takes one or three process cycles. Load-immediate, jump and no-op use one. A conditional instruction whose condition is false also uses one, and it skips the EXEC ROM access. An ALU operation is two bytes long: an opcode byte, then a function byte. Its second and third process cycles each send one nibble of the operands through the table. The first result nibble is held in a temporary latch until the second pass merges both nibbles into a byte.

The block holds four 8-bit registers A, B, X and Y. {Y,X} forms the RAM index. The block also holds the program counter. It drives the register load enables and brings out the register contents.

Top module: `lut_cpu_seq`

## Requirements
- R1: After reset the slot output is 0 (FETCH). It then advances 0,1,2,3 (FETCH, READ, EXEC, WRITE) by one each clock and wraps to 0.
- R2: rom_re is high only in slots 0 and 2. ram_re and ram_we are high only in slots 1 and 3. ram_we is high only in slot 3. ROM and RAM are never both accessed in the same slot.
- R3: Reset clears pc and all registers. Opcode bits are: [7:6] kind (00 no-op, 01 load-immediate, 10 ALU, 11 jump), [5] conditional, [4] RAM operand, [3] RAM store, [2:1] destination (0 A, 1 B, 2 X, 3 Y), [0] ignored. Every byte fetched in slot 0 is read from program space at pc, and pc then increments.
- R4: A no-op (0x00) takes one process cycle, makes one ROM access, and advances pc by 1.
- R5: A load-immediate reads the byte after the opcode from ROM in EXEC, loads it into the destination in WRITE, and advances pc by 2, all within one process cycle.
- R6: When the store bit is set, the byte written to the destination in a load-immediate or ALU instruction is also written to RAM at {Y,X}, using the index values held before that WRITE slot.
- R7: When the conditional bit is set and the cond input is low during the opcode's FETCH slot, a load-immediate or jump makes no EXEC ROM access, loads no register, writes no RAM, and advances pc by 2 in one process cycle.
- R8: A jump reads its target byte in EXEC and loads it into pc in WRITE. The next fetch comes from the target.
- R9: An ALU instruction takes three process cycles and writes its destination only at the end of the third. Its operand is RAM[{Y,X}] when bit 4 is set and register B otherwise, sampled in the second cycle's READ slot. Its pc advances by 2.
- R10: Each ALU pass reads table space (rom_tbl high) at {function[7:0], A nibble[3:0], operand nibble[3:0]}. The low nibbles go in the second cycle and the high nibbles in the third. Only rom_data[3:0] is used. The result byte is {high pass, low pass}.
- R11: With a table whose function 0xFF entry returns the operand nibble, function 0xFF delivers the operand byte unchanged.
- R12: reg_ld is at most one-hot and is high only in slot 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot | output | 2 | Current slot: 0 FETCH, 1 READ, 2 EXEC, 3 WRITE |
| rom_re | output | 1 | ROM read strobe |
| rom_tbl | output | 1 | ROM access targets the ALU table space |
| rom_addr | output | 16 | ROM address: pc or table index |
| rom_data | input | 8 | ROM read data, valid within the slot |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM index {Y,X} |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid within the slot |
| cond | input | 1 | Condition, sampled in the opcode FETCH slot |
| reg_ld | output | 4 | Register load enables (A, B, X, Y) |
| pc | output | PC_W | Program counter |
| regs | output | 32 | Register contents {Y,X,B,A} |

## Verification
A program of k process cycles has all its effects on registers, pc and RAM in place at the 4k-th rising edge after reset is released. Each bench run releases reset at a falling edge, waits exactly 4k rising edges, and samples at the next falling edge. An ALU result is due at the end of its third process cycle, not earlier, so the bench also samples one process cycle early and expects the destination still clear. ROM accesses are counted at rising edges over the same window, which shows whether an EXEC read was skipped or made.

// File: rtl/lutseq_pkg.sv
package lutseq_pkg;
  localparam int DW     = 8;
  localparam int NW     = DW / 2;
  localparam int ROM_AW = DW + 2 * NW;
  localparam int RAM_AW = 2 * DW;
  localparam int RSEL_W = 2;
  localparam int NREG   = 1 << RSEL_W;
  localparam int R_A    = 0;
  localparam int R_B    = 1;
  localparam int R_X    = 2;
  localparam int R_Y    = 3;

  typedef enum logic [1:0] {SL_FETCH = 2'd0, SL_READ = 2'd1, SL_EXEC = 2'd2, SL_WRITE = 2'd3} slot_e;
  typedef enum logic [1:0] {K_NOP = 2'd0, K_LDI = 2'd1, K_ALU = 2'd2, K_JMP = 2'd3} kind_e;
  typedef enum logic [1:0] {ST_OP = 2'd0, ST_ARG = 2'd1, ST_HI = 2'd2} step_e;

  // upper seven opcode bits; bit 0 of the opcode byte is ignored
  typedef struct packed {
    kind_e             kind;
    logic              cnd;
    logic              msrc;
    logic              mdst;
    logic [RSEL_W-1:0] dst;
  } op_t;
  localparam int OP_W = $bits(op_t);

  function automatic logic [ROM_AW-1:0] tbl_addr(input logic [DW-1:0] fn,
                                                 input logic [NW-1:0] a,
                                                 input logic [NW-1:0] b);
    return {fn, a, b};
  endfunction

  function automatic logic [NW-1:0] pick_nib(input logic [DW-1:0] v, input logic hi);
    return hi ? v[DW-1:NW] : v[NW-1:0];
  endfunction

  function automatic logic [DW-1:0] join_nib(input logic [NW-1:0] hi, input logic [NW-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/lutseq_slot_timer.sv
module lutseq_slot_timer
  import lutseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output slot_e sl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sl <= SL_FETCH;
    else        sl <= slot_e'(sl + 2'd1);
  end
endmodule

// File: rtl/lutseq_decode.sv
module lutseq_decode
  import lutseq_pkg::*;
(
  input  op_t  ir,
  input  logic cond_q,
  output logic is_ldi,
  output logic is_jmp,
  output logic is_alu,
  output logic take,
  output logic skip
);
  logic has_imm;
  always_comb begin
    is_ldi  = (ir.kind == K_LDI);
    is_jmp  = (ir.kind == K_JMP);
    is_alu  = (ir.kind == K_ALU);
    has_imm = is_ldi || is_jmp;
    take    = has_imm && (!ir.cnd || cond_q);
    skip    = has_imm && ir.cnd && !cond_q;
  end
endmodule

// File: rtl/lutseq_regfile.sv
module lutseq_regfile
  import lutseq_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   ld,
  input  logic [W-1:0]   wdata,
  output logic [N*W-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     r <= '0;
      else if (ld[g]) r <= wdata;
    end
    assign q[g*W +: W] = r;
  end
endmodule

// File: rtl/lut_cpu_seq.sv
module lut_cpu_seq
  import lutseq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [1:0]           slot,
  output logic                 rom_re,
  output logic                 rom_tbl,
  output logic [ROM_AW-1:0]    rom_addr,
  input  logic [DW-1:0]        rom_data,
  output logic                 ram_re,
  output logic                 ram_we,
  output logic [RAM_AW-1:0]    ram_addr,
  output logic [DW-1:0]        ram_wdata,
  input  logic [DW-1:0]        ram_rdata,
  input  logic                 cond,
  output logic [NREG-1:0]      reg_ld,
  output logic [PC_W-1:0]      pc,
  output logic [NREG*DW-1:0]   regs
);
  slot_e           sl;
  step_e           step;
  op_t             ir;
  logic            cond_q;
  logic [DW-1:0]   func_q, opnd_q, exe_q;
  logic [NW-1:0]   tmp_q;
  logic [PC_W-1:0] pc_q;
  logic            is_ldi, is_jmp, is_alu, take, skip;
  logic [DW-1:0]   a_reg, b_reg, x_reg, y_reg;
  logic            hi_pass;
  logic [NW-1:0]   a_nib, b_nib;

  // named slot events, also observed by the checker
  logic fetch_go, rd_slot, exec_imm, exec_skip, exec_tbl, wr_go, jmp_go;

  lutseq_slot_timer u_slot (.clk(clk), .rst_n(rst_n), .sl(sl));

  lutseq_decode u_dec (
    .ir(ir), .cond_q(cond_q), .is_ldi(is_ldi), .is_jmp(is_jmp),
    .is_alu(is_alu), .take(take), .skip(skip)
  );

  lutseq_regfile #(.N(NREG), .W(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .ld(reg_ld), .wdata(exe_q), .q(regs)
  );

  assign a_reg = regs[R_A*DW +: DW];
  assign b_reg = regs[R_B*DW +: DW];
  assign x_reg = regs[R_X*DW +: DW];
  assign y_reg = regs[R_Y*DW +: DW];

  assign hi_pass = (step == ST_HI);
  assign a_nib   = pick_nib(a_reg, hi_pass);
  assign b_nib   = pick_nib(opnd_q, hi_pass);

  always_comb begin
    fetch_go  = (sl == SL_FETCH) && (step != ST_HI);
    rd_slot   = (sl == SL_READ) && (step == ST_ARG);
    exec_imm  = (sl == SL_EXEC) && (step == ST_OP) && take;
    exec_skip = (sl == SL_EXEC) && (step == ST_OP) && skip;
    exec_tbl  = (sl == SL_EXEC) && (step != ST_OP);
    wr_go     = (sl == SL_WRITE) &&
                (((step == ST_OP) && take && is_ldi) || (step == ST_HI));
    jmp_go    = (sl == SL_WRITE) && (step == ST_OP) && take && is_jmp;
  end

  always_comb begin
    slot      = sl;
    rom_re    = fetch_go || exec_imm || exec_tbl;
    rom_tbl   = exec_tbl;
    rom_addr  = exec_tbl ? tbl_addr(func_q, a_nib, b_nib) : ROM_AW'(pc_q);
    ram_re    = rd_slot && ir.msrc;
    ram_we    = wr_go && ir.mdst;
    ram_addr  = {y_reg, x_reg};
    ram_wdata = exe_q;
    pc        = pc_q;
    reg_ld    = '0;
    if (wr_go) reg_ld[ir.dst] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= ST_OP;
      ir     <= '0;
      cond_q <= 1'b0;
      func_q <= '0;
      opnd_q <= '0;
      exe_q  <= '0;
      tmp_q  <= '0;
      pc_q   <= '0;
    end else begin
      if (fetch_go) begin
        pc_q <= pc_q + PC_W'(1);
        if (step == ST_OP) begin
          ir     <= op_t'(rom_data[DW-1 -: OP_W]);
          cond_q <= cond;
        end else begin
          func_q <= rom_data;
        end
      end
      if (rd_slot) opnd_q <= ir.msrc ? ram_rdata : b_reg;
      if (exec_imm) begin
        exe_q <= rom_data;
        pc_q  <= pc_q + PC_W'(1);
      end
      if (exec_skip) pc_q <= pc_q + PC_W'(1);
      if (exec_tbl) begin
        if (step == ST_ARG) tmp_q <= rom_data[NW-1:0];
        else                exe_q <= join_nib(rom_data[NW-1:0], tmp_q);
      end
      if (jmp_go) pc_q <= PC_W'(exe_q);
      if (sl == SL_WRITE) begin
        unique case (step)
          ST_OP:   step <= is_alu ? ST_ARG : ST_OP;
          ST_ARG:  step <= ST_HI;
          default: step <= ST_OP;
        endcase
      end
    end
  end
endmodule

// File: rtl/lut_cpu_seq_chk.sv
module lut_cpu_seq_chk
  import lutseq_pkg::*;
#(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      slot,
  input logic            rom_re,
  input logic            rom_tbl,
  input logic            ram_re,
  input logic            ram_we,
  input logic [NREG-1:0] reg_ld,
  input logic [PC_W-1:0] pc,
  input logic            exec_skip
);
  p_slot_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot == 2'($past(slot) + 2'd1)));

  p_mem_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_re && (ram_re || ram_we)));

  p_rom_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |-> (slot == 2'd0 || slot == 2'd2));

  p_ram_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> (slot == 2'd1 || slot == 2'd3));

  p_we_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (slot == 2'd3));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == 2'd0 && rom_re) |=> (pc == PC_W'($past(pc) + PC_W'(1))));

  p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_skip |-> !rom_re);

  p_tbl_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_tbl |-> (rom_re && slot == 2'd2));

  p_ld_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_ld));

  p_ld_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld != '0) |-> (slot == 2'd3));
endmodule

bind lut_cpu_seq lut_cpu_seq_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .rom_re(rom_re), .rom_tbl(rom_tbl),
  .ram_re(ram_re), .ram_we(ram_we), .reg_ld(reg_ld), .pc(pc), .exec_skip(exec_skip)
);

// File: tb/sim_lut_cpu_seq.sv
module sim_lut_cpu_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  slot;
  logic        rom_re, rom_tbl, ram_re, ram_we, cond;
  logic [15:0] rom_addr, ram_addr;
  logic [7:0]  rom_data, ram_wdata, ram_rdata;
  logic [3:0]  reg_ld;
  logic [7:0]  pc;
  logic [31:0] regs;

  logic [7:0] prog  [0:255];
  logic [7:0] ram_m [0:255];
  int n_chk = 0, n_fail = 0, rom_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lut_cpu_seq #(.PC_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .slot(slot), .rom_re(rom_re), .rom_tbl(rom_tbl),
    .rom_addr(rom_addr), .rom_data(rom_data), .ram_re(ram_re), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .cond(cond), .reg_ld(reg_ld), .pc(pc), .regs(regs)
  );

  // bench table: 01 xor, 02 and, 03 add mod 16, FF pass operand
  function automatic logic [3:0] tfn(input logic [7:0] f, input logic [3:0] a, input logic [3:0] b);
    case (f)
      8'h01:   return a ^ b;
      8'h02:   return a & b;
      8'h03:   return 4'(a + b);
      8'hFF:   return b;
      default: return 4'h0;
    endcase
  endfunction

  // upper data nibble carries junk (the A nibble) that must be ignored
  always_comb rom_data = rom_tbl ? {rom_addr[7:4], tfn(rom_addr[15:8], rom_addr[7:4], rom_addr[3:0])}
                                 : prog[rom_addr[7:0]];
  assign ram_rdata = ram_m[ram_addr[7:0]];
  always @(posedge clk) if (ram_we) ram_m[ram_addr[7:0]] <= ram_wdata;
  always @(posedge clk) if (rst_n && rom_re) rom_cnt++;

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all;
    for (int i = 0; i < 256; i++) begin prog[i] = 8'h00; ram_m[i] = 8'h00; end
  endtask

  // k process cycles: results due at the 4k-th rising edge after release
  task automatic run(input int k);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rom_cnt = 0;
    repeat (4 * k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    cond = 1'b0;
    clear_all();
    // reset state, R3 and R1
    @(negedge clk);
    chk("R3", "reset pc", pc, 0);
    chk("R3", "reset regs", regs, 0);
    chk("R1", "reset slot", slot, 0);
    rst_n = 1'b1;
    for (int i = 1; i < 9; i++) begin
      @(negedge clk);
      chk("R1", "slot order", slot, i % 4);
    end

    // R4 no-op
    clear_all();
    run(1);
    chk("R4", "nop pc", pc, 1);
    chk("R4", "nop rom reads", rom_cnt, 1);
    run(3);
    chk("R4", "three nops pc", pc, 3);
    chk("R4", "nop regs", regs, 0);

    // R5 load immediate to every destination
    for (int d = 0; d < 4; d++) begin
      clear_all();
      prog[0] = 8'h40 | 8'(d << 1);
      prog[1] = 8'(8'h5A + d * 8'h11);
      run(1);
      chk("R5", "ldi dest", rg(d), 8'(8'h5A + d * 8'h11));
      chk("R5", "ldi pc", pc, 2);
      chk("R5", "ldi rom reads", rom_cnt, 2);
      chk("R5", "ldi one-hot", $countones(regs), $countones(8'(8'h5A + d * 8'h11)));
    end

    // R7 conditional load, false then true
    clear_all();
    prog[0] = 8'h62; prog[1] = 8'h99;
    cond = 1'b0;
    run(1);
    chk("R7", "skipped load B", rg(1), 0);
    chk("R7", "skipped pc", pc, 2);
    chk("R7", "skipped rom reads", rom_cnt, 1);
    cond = 1'b1;
    run(1);
    chk("R7", "taken load B", rg(1), 8'h99);
    chk("R7", "taken rom reads", rom_cnt, 2);
    clear_all();
    prog[0] = 8'h68; prog[1] = 8'h44; ram_m[0] = 8'hEE;
    cond = 1'b0;
    run(1);
    chk("R7", "skipped store ram", ram_m[0], 8'hEE);
    chk("R7", "skipped store A", rg(0), 0);
    cond = 1'b0;

    // R8 jump, plain and conditional
    clear_all();
    prog[0] = 8'hC0; prog[1] = 8'h20; prog[8'h20] = 8'h44; prog[8'h21] = 8'h81;
    run(1);
    chk("R8", "jump target pc", pc, 8'h20);
    run(2);
    chk("R8", "after jump pc", pc, 8'h22);
    chk("R8", "after jump X", rg(2), 8'h81);
    clear_all();
    prog[0] = 8'hE0; prog[1] = 8'h20; prog[2] = 8'h40; prog[3] = 8'h12;
    run(2);
    chk("R7", "cond jump not taken A", rg(0), 8'h12);
    chk("R8", "cond jump not taken pc", pc, 4);

    // R6 RAM store at index {Y,X}
    clear_all();
    prog[0] = 8'h48; prog[1] = 8'h77;
    run(1);
    chk("R6", "store ram[0]", ram_m[0], 8'h77);
    chk("R6", "store A", rg(0), 8'h77);
    clear_all();
    prog[0] = 8'h44; prog[1] = 8'h05; prog[2] = 8'h4A; prog[3] = 8'h5A;
    run(2);
    chk("R6", "indexed store ram[5]", ram_m[5], 8'h5A);
    chk("R6", "ram[0] untouched", ram_m[0], 0);

    // R9 timing: destination due at end of third ALU cycle
    clear_all();
    prog[0] = 8'h40; prog[1] = 8'h36; prog[2] = 8'h42; prog[3] = 8'h0F;
    prog[4] = 8'h84; prog[5] = 8'h01;
    run(4);
    chk("R9", "alu not yet written", rg(2), 0);
    run(5);
    chk("R9", "alu written", rg(2), 8'h39);
    chk("R9", "alu pc", pc, 6);
    chk("R10", "alu rom reads", rom_cnt, 8);

    // R9/R6 RAM operand and RAM store
    clear_all();
    ram_m[0] = 8'h3C;
    prog[0] = 8'h40; prog[1] = 8'hA5; prog[2] = 8'h98; prog[3] = 8'h01;
    run(4);
    chk("R9", "ram operand xor", rg(0), 8'h99);
    chk("R6", "alu store ram", ram_m[0], 8'h99);

    // R10/R11 sweep of functions and operands
    for (int fi = 0; fi < 4; fi++) begin
      logic [7:0] f;
      f = (fi == 3) ? 8'hFF : 8'(fi + 1);
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          logic [7:0] a, b, e;
          a = 8'(i * 8'h1B + 3);
          b = 8'(j * 8'h35 + 7);
          e = {tfn(f, a[7:4], b[7:4]), tfn(f, a[3:0], b[3:0])};
          clear_all();
          prog[0] = 8'h40; prog[1] = a; prog[2] = 8'h42; prog[3] = b;
          prog[4] = 8'h84; prog[5] = f;
          run(5);
          if (f == 8'hFF) chk("R11", "identity", rg(2), b);
          else            chk("R10", "table result", rg(2), e);
        end
      end
    end

    finish_up();
  end
endmodule